// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the program counter of a small processor and picks its next value once per clock. A command code chooses what happens. The counter can step forward by the current instruction's length, load an absolute target, load the target only when the zero flag is set, or add a signed displacement to the address of the next instruction. It can also call a subroutine, which saves the next-instruction address on a small hardware stack before jumping. A return pops that address back into the counter.

The same command input sets and clears an interrupt-enable bit. The decoder ahead of the block supplies four inputs: the command, a target or displacement, the instruction length and the zero flag. The block reports the counter, the interrupt-enable bit and the stack state. Two one-cycle flags mark a call made while the stack is full and a return made while it is empty. In both cases the counter is left where it was.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low and on the first cycle after it is released, pc is 0, intEn is 0, stackDepth is 0, stackEmpty is 1, and stackFull, overflow and underflow are 0.
- R2: Command code 0 (no command) advances pc by instLen on each clock. Unassigned codes 8 to 15 behave the same way.
- R3: Command code 1 (jump) loads pc with target.
- R4: Command code 2 (jump if zero) loads pc with target when zeroFlag is 1. When zeroFlag is 0, it advances pc by instLen.
- R5: Command code 3 (relative jump) loads pc with pc + instLen + target. Here target is a two's-complement displacement and the sum wraps modulo 2^ADDR_W.
- R6: Command code 4 (call) with a stack that is not full pushes pc + instLen, loads pc with target and raises stackDepth by one.
- R7: Command code 5 (return) with a stack that is not empty loads pc with the most recently pushed address that has not yet been popped. It also lowers stackDepth by one.
- R8: A call while stackDepth equals DEPTH (8 by default) leaves pc and the stack unchanged. It raises overflow for exactly the following cycle.
- R9: A return while the stack is empty leaves pc unchanged and raises underflow for exactly the following cycle.
- R10: Command code 6 sets intEn and code 7 clears it. Both advance pc by instLen. No other command changes intEn.
- R11: stackFull is 1 exactly when stackDepth equals DEPTH. stackEmpty is 1 exactly when stackDepth is 0. stackDepth never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | Command code for this cycle |
| target | input | ADDR_W | Absolute target, or signed displacement for a relative jump |
| instLen | input | LEN_W | Length of the current instruction |
| zeroFlag | input | 1 | Zero condition from the ALU |
| pc | output | ADDR_W | Current program counter |
| intEn | output | 1 | Interrupt-enable bit |
| stackDepth | output | $clog2(DEPTH+1) | Number of saved return addresses |
| stackFull | output | 1 | Stack holds DEPTH entries |
| stackEmpty | output | 1 | Stack holds no entries |
| overflow | output | 1 | One-cycle flag: a call was refused because the stack was full |
| underflow | output | 1 | One-cycle flag: a return was refused because the stack was empty |

## Verification
Corruption of the counter register shows up on pc in the cycle after the faulty edge. Every command's result feeds the next one, so the error never heals. A wrong stack pointer or entry stays hidden until a return reaches the bad slot. The bench therefore nests calls deeply and unwinds them all before it runs a long mixed sequence. An off-by-one in the depth count shows on stackDepth at once, and it shows on the full and empty flags only at the boundaries. For that reason the bench fills the stack, overruns it and drains it past empty.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [3:0] {
    CMD_NONE = 4'd0,
    CMD_JMP  = 4'd1,
    CMD_JZ   = 4'd2,
    CMD_JREL = 4'd3,
    CMD_CALL = 4'd4,
    CMD_RET  = 4'd5,
    CMD_EI   = 4'd6,
    CMD_DI   = 4'd7
  } cmd_e;

  typedef enum logic [2:0] {
    SEL_SEQ,
    SEL_ABS,
    SEL_REL,
    SEL_POP,
    SEL_HOLD
  } pc_sel_e;

  typedef struct packed {
    pc_sel_e pcSel;
    logic    push;
    logic    pop;
    logic    ieSet;
    logic    ieClr;
    logic    ovfHit;
    logic    unfHit;
  } strobes_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic       zeroFlag,
  input  logic       stackFull,
  input  logic       stackEmpty,
  output strobes_t   strb
);

  always_comb begin
    strb       = '0;
    strb.pcSel = SEL_SEQ;
    case (cmd)
      CMD_JMP:  strb.pcSel = SEL_ABS;
      CMD_JZ:   strb.pcSel = zeroFlag ? SEL_ABS : SEL_SEQ;
      CMD_JREL: strb.pcSel = SEL_REL;
      CMD_CALL: begin
        if (stackFull) begin
          strb.pcSel  = SEL_HOLD;
          strb.ovfHit = 1'b1;
        end else begin
          strb.pcSel = SEL_ABS;
          strb.push  = 1'b1;
        end
      end
      CMD_RET: begin
        if (stackEmpty) begin
          strb.pcSel  = SEL_HOLD;
          strb.unfHit = 1'b1;
        end else begin
          strb.pcSel = SEL_POP;
          strb.pop   = 1'b1;
        end
      end
      CMD_EI:   strb.ieSet = 1'b1;
      CMD_DI:   strb.ieClr = 1'b1;
      default:  strb.pcSel = SEL_SEQ;
    endcase
  end

  always_comb begin
    assert (!(strb.push && strb.pop)) else $error("AST_PUSH_POP_EXCL"); // R7
  end

endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 3,
  parameter int DEPTH  = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [ADDR_W-1:0]  target,
  input  logic [LEN_W-1:0]   instLen,
  output logic [ADDR_W-1:0]  pc,
  output logic               intEn,
  output logic [DEPTH_W-1:0] stackDepth,
  output logic               stackFull,
  output logic               stackEmpty,
  output logic               overflow,
  output logic               underflow
);

  logic [ADDR_W-1:0]  slot [DEPTH];
  logic [DEPTH_W-1:0] sp;
  logic [DEPTH_W-1:0] spDec;
  logic [IDX_W-1:0]   pushIdx;
  logic [IDX_W-1:0]   topIdx;
  logic [ADDR_W-1:0]  seqPc;
  logic [ADDR_W-1:0]  relPc;
  logic [ADDR_W-1:0]  topVal;

  assign seqPc   = pc + ADDR_W'(instLen);
  assign relPc   = seqPc + target;
  assign spDec   = sp - DEPTH_W'(1);
  assign pushIdx = sp[IDX_W-1:0];
  assign topIdx  = spDec[IDX_W-1:0];
  assign topVal  = slot[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
    end else begin
      case (strb.pcSel)
        SEL_SEQ: pc <= seqPc;
        SEL_ABS: pc <= target;
        SEL_REL: pc <= relPc;
        SEL_POP: pc <= topVal;
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          sp <= '0;
    else if (strb.push) sp <= sp + DEPTH_W'(1);
    else if (strb.pop)  sp <= spDec;
  end

  always_ff @(posedge clk) begin
    if (rstN && strb.push) slot[pushIdx] <= seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn     <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (strb.ieSet)      intEn <= 1'b1;
      else if (strb.ieClr) intEn <= 1'b0;
      overflow  <= strb.ovfHit;
      underflow <= strb.unfHit;
    end
  end

  assign stackDepth = sp;
  assign stackFull  = (sp == DEPTH_W'(DEPTH));
  assign stackEmpty = (sp == '0);

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= DEPTH_W'(DEPTH)); // R11
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> stackDepth == $past(stackDepth) + DEPTH_W'(1)); // R6
  AST_POP_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> pc == $past(topVal)); // R7

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 3,
  parameter int DEPTH  = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         cmd,
  input  logic [ADDR_W-1:0]  target,
  input  logic [LEN_W-1:0]   instLen,
  input  logic               zeroFlag,
  output logic [ADDR_W-1:0]  pc,
  output logic               intEn,
  output logic [DEPTH_W-1:0] stackDepth,
  output logic               stackFull,
  output logic               stackEmpty,
  output logic               overflow,
  output logic               underflow
);

  strobes_t strb;

  pcseq_ctrl uCtrl (
    .cmd        (cmd),
    .zeroFlag   (zeroFlag),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .strb       (strb)
  );

  pcseq_datapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .DEPTH  (DEPTH)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .target     (target),
    .instLen    (instLen),
    .pc         (pc),
    .intEn      (intEn),
    .stackDepth (stackDepth),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .overflow   (overflow),
    .underflow  (underflow)
  );

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    cmd == 4'd0 |=> pc == $past(pc) + ADDR_W'($past(instLen))); // R2
  AST_JMP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmd == 4'd1 |=> pc == $past(target)); // R3
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'd4 && stackFull) |=> (overflow && $stable(pc) && $stable(stackDepth))); // R8
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'd5 && stackEmpty) |=> (underflow && $stable(pc))); // R9
  AST_IE_SET: assert property (@(posedge clk) disable iff (!rstN)
    cmd == 4'd6 |=> intEn); // R10
  AST_IE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    cmd == 4'd7 |=> !intEn); // R10

endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cmd = '0;
  logic [15:0] target = '0;
  logic [2:0]  instLen = '0;
  logic        zeroFlag = 1'b0;
  logic [15:0] pc;
  logic        intEn;
  logic [3:0]  stackDepth;
  logic        stackFull, stackEmpty, overflow, underflow;

  always #5 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .target(target), .instLen(instLen),
    .zeroFlag(zeroFlag), .pc(pc), .intEn(intEn), .stackDepth(stackDepth),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .overflow(overflow),
    .underflow(underflow)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mPc;
  logic        mIe, mOvf, mUnf;
  logic [15:0] stk[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string pcTag(input logic [3:0] c);
    case (c)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic compareAll(input string pcReq);
    chk(pcReq, "pc", int'(pc), int'(mPc));
    chk("R10", "intEn", int'(intEn), int'(mIe));
    chk("R11", "stackDepth", int'(stackDepth), stk.size());
    chk("R11", "stackFull", int'(stackFull), int'(stk.size() == 8));
    chk("R11", "stackEmpty", int'(stackEmpty), int'(stk.size() == 0));
    chk("R8", "overflow", int'(overflow), int'(mOvf));
    chk("R9", "underflow", int'(underflow), int'(mUnf));
  endtask

  task automatic step(input logic [3:0] c, input logic [15:0] t,
                      input logic [2:0] l, input logic z);
    string req;
    cmd = c; target = t; instLen = l; zeroFlag = z;
    @(posedge clk);
    mOvf = 1'b0;
    mUnf = 1'b0;
    req = pcTag(c);
    case (c)
      4'd1: mPc = t;
      4'd2: mPc = z ? t : mPc + 16'(l);
      4'd3: mPc = mPc + 16'(l) + t;
      4'd4: begin
        if (stk.size() == 8) begin mOvf = 1'b1; req = "R8"; end
        else begin stk.push_back(mPc + 16'(l)); mPc = t; end
      end
      4'd5: begin
        if (stk.size() == 0) begin mUnf = 1'b1; req = "R9"; end
        else mPc = stk.pop_back();
      end
      4'd6: begin mIe = 1'b1; mPc = mPc + 16'(l); end
      4'd7: begin mIe = 1'b0; mPc = mPc + 16'(l); end
      default: mPc = mPc + 16'(l);
    endcase
    @(negedge clk);
    compareAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    mPc = '0; mIe = 1'b0; mOvf = 1'b0; mUnf = 1'b0;
    repeat (3) @(negedge clk);
    compareAll("R1");               // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");               // R1 after release
    chk("R1", "pc after reset", int'(pc), 0);

    step(4'd0, 16'h1234, 3'd1, 1'b0);    // R2
    step(4'd0, 16'h0, 3'd4, 1'b1);       // R2
    step(4'd9, 16'hAAAA, 3'd2, 1'b1);    // R2 unassigned code
    step(4'd15, 16'h5555, 3'd7, 1'b0);   // R2 unassigned code
    step(4'd1, 16'h0100, 3'd3, 1'b0);    // R3
    step(4'd2, 16'h0200, 3'd2, 1'b0);    // R4 not taken
    step(4'd2, 16'h0300, 3'd2, 1'b1);    // R4 taken
    step(4'd3, 16'h0010, 3'd2, 1'b0);    // R5 forward
    step(4'd3, 16'hFFF0, 3'd1, 1'b0);    // R5 backward
    step(4'd1, 16'h0004, 3'd1, 1'b0);
    step(4'd3, 16'hFFF0, 3'd1, 1'b0);    // R5 wrap below zero
    step(4'd6, 16'h9999, 3'd1, 1'b0);    // R10 set
    step(4'd0, 16'h0, 3'd1, 1'b0);       // R10 held
    step(4'd1, 16'h0400, 3'd1, 1'b1);    // R10 held across jump
    step(4'd7, 16'h0, 3'd2, 1'b0);       // R10 clear

    for (int i = 0; i < 8; i++)          // R6 fill stack
      step(4'd4, 16'h1000 + 16'(i * 16'h100), 3'(i % 7 + 1), 1'b0);
    chk("R11", "full after 8 calls", int'(stackFull), 1);
    step(4'd4, 16'h7777, 3'd3, 1'b0);    // R8 overflow
    step(4'd0, 16'h0, 3'd1, 1'b0);       // R8 flag one cycle only
    for (int i = 0; i < 8; i++)          // R7 LIFO unwind
      step(4'd5, 16'h0, 3'd1, 1'b0);
    step(4'd5, 16'h0, 3'd1, 1'b0);       // R9 underflow
    step(4'd5, 16'h0, 3'd1, 1'b0);       // R9 repeated
    step(4'd0, 16'h0, 3'd2, 1'b0);       // R9 flag clears

    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0], {lfsr[7:0], lfsr[15:8]}, lfsr[6:4], lfsr[9]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule